// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block is the transmit side of an SPI master: one holding register in front of an 8-bit shift register, four active-low select lines, and a sequencer. The sequencer decides after every word whether the active select stays low or goes high. Software writes a byte together with a select code. The byte moves into the shifter as soon as the shifter is free, and the holding register then reports empty so that the next byte can be written. When a word ends, the sequencer waits out an inter-transfer delay set for that select. At the end of the delay it looks at four things: whether a next word is pending, which select that word targets, the per-select hold option, and a one-shot last-transfer flag.

Each select has its own configuration: a hold bit that keeps the select low after a word when nothing follows, and a delay in units of a fixed number of system clocks. A mode register sets the SCK half period, turns on a decoded mode in which the four lines carry a 4-bit slave number for an external 1-of-n decoder, and arms the last-transfer flag. Transfers run in SPI mode 0 with the MSB first. Every completed word leaves its received byte in a read register, with a full flag.

Top module: `spi_cs_seq`

## Requirements
- R1: After reset, `cs_n` is 4'b1111, `sck` is 0, `tx_empty` is 1 and `rx_full` is 0. The hold bits and delays are 0, decoded mode is off and the half period is 2.
- R2: A write to address 0 puts `wr_data[7:0]` into the holding register and `wr_data[11:8]` in as the select code. The byte goes out MSB first: eight `sck` pulses, `mosi` changes only while `sck` is low, `sck` stays low outside the shift phase, and `miso` is sampled on each rising `sck` edge.
- R3: At the end of each word, `rx_data` holds the eight sampled `miso` bits (first bit as MSB) and `rx_full` rises. A one-cycle `rd_en` clears `rx_full`.
- R4: `tx_empty` falls on the clock edge that takes a byte. When the sequencer is idle, it rises again on the next edge, when the byte moves into the shifter. A write to address 0 while `tx_empty` is 0 is ignored.
- R5: The decision point comes D×32 system clocks after the last falling `sck` edge of a word, where D is the select's delay. If a word for the same select is pending at that point, the select stays low and the next word follows. If no word is pending, the hold bit is 0 and the flag is clear, the select goes high.
- R6: A write to address 1 sets the configuration of select `wr_data[9:8]`: the hold bit is `wr_data[12]` and the delay is `wr_data[7:0]`. With the hold bit set and nothing pending, the select stays low indefinitely.
- R7: When the pending word targets a different select, the current select goes high first. All lines stay high for exactly one SCK period (twice the half period, in system clocks), and then the new select goes low before its first `sck` edge.
- R8: A write to address 2 sets the last-transfer flag from `wr_data[14]`. A word loaded while the flag is set releases its select at the decision point, even with the hold bit set. The flag clears when that release happens, so the next word on a held select stays low again.
- R9: The same mode write sets the SCK half period from `wr_data[7:0]` in system clocks. Values below 2 act as 2, and `sck` stays high for exactly the half period.
- R10: The same mode write sets decoded mode from `wr_data[13]`. In decoded mode, `cs_n` carries the 4-bit select code during a transfer. A data write with code 4'b1111 is ignored: `tx_empty` stays 1 and no `sck` edge or select change follows.
- R11: In normal mode, exactly the line `wr_data[9:8]` of the data write goes low. In both modes, the configuration used for a word is the one at the index formed by the low two bits of its select code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 data, 1 select configuration, 2 mode |
| wr_data | input | 15 | Write value; field layout depends on the address |
| rd_en | input | 1 | Receive byte read strobe; clears rx_full |
| tx_empty | output | 1 | Holding register can take a byte |
| rx_full | output | 1 | A received byte is waiting |
| rx_data | output | 8 | Last received byte |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low select lines, or a decoded slave number |

## Verification
The bench builds the block with its default parameters: 8-bit words, four select lines and a delay unit of 32 clocks. These give the 4-bit decoded codes and the 64-clock window of a delay value of 2. At run time it programs half periods of 2, 5 and 1, which exercises the clamp as well as the plain divider. It runs delays of 0 and 2 against reloads that arrive during the shift, just after it, and inside the delay window. It loops `miso` back from `mosi`, straight and inverted, so that every received byte is known in advance.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_DELAY = 3'd3,
        ST_GAP   = 3'd4
    } seq_state_e;

    localparam logic [1:0] ADDR_TXD  = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_MODE = 2'd2;

endpackage

// File: rtl/spi_cs_clkgen.sv
module spi_cs_clkgen #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [DIVW-1:0] half,
    output logic            tick
);
    logic [DIVW-1:0] cnt_d, cnt_q;
    logic [DIVW-1:0] eff;

    always_comb begin
        eff   = (half < DIVW'(2)) ? DIVW'(2) : half;
        tick  = en && (cnt_q == eff - DIVW'(1));
        cnt_d = cnt_q + DIVW'(1);
        if (!en || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9: a half period is never shorter than two clocks
    a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/spi_cs_shifter.sv
module spi_cs_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] ld_data,
    input  logic          step,
    input  logic          miso,
    output logic          sck,
    output logic          mosi,
    output logic          done,
    output logic [DW-1:0] rx_word
);
    localparam int BW = (DW > 2) ? $clog2(DW) : 1;

    typedef struct packed {
        logic [DW-1:0] sreg;
        logic [DW-1:0] rxs;
        logic          sck;
        logic [BW-1:0] bitn;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        done = 1'b0;
        if (load) begin
            sh_d.sreg = ld_data;
            sh_d.sck  = 1'b0;
            sh_d.bitn = '0;
        end else if (step) begin
            if (!sh_q.sck) begin
                sh_d.sck = 1'b1;
                sh_d.rxs = {sh_q.rxs[DW-2:0], miso};
            end else begin
                sh_d.sck  = 1'b0;
                sh_d.sreg = {sh_q.sreg[DW-2:0], 1'b0};
                sh_d.bitn = sh_q.bitn + BW'(1);
                if (sh_q.bitn == BW'(DW-1)) done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sck     = sh_q.sck;
    assign mosi    = sh_q.sreg[DW-1];
    assign rx_word = sh_q.rxs;

    // R2: data out only moves while the clock is low
    a_r2_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && !load && $past(sck)) |-> $stable(mosi));

endmodule

// File: rtl/spi_cs_selmap.sv
module spi_cs_selmap #(
    parameter int NCS = 4
) (
    input  logic           active,
    input  logic           decoded,
    input  logic [NCS-1:0] code,
    output logic [NCS-1:0] cs_n
);
    localparam int IDXW = $clog2(NCS);

    for (genvar i = 0; i < NCS; i++) begin : g_line
        assign cs_n[i] = !active ? 1'b1 :
                         decoded ? code[i] :
                         (code[IDXW-1:0] != IDXW'(i));
    end

endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq #(
    parameter int DW       = 8,
    parameter int NCS      = 4,
    parameter int DLY_UNIT = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [DW+NCS+2:0]   wr_data,
    input  logic                rd_en,
    output logic                tx_empty,
    output logic                rx_full,
    output logic [DW-1:0]       rx_data,
    output logic                sck,
    output logic                mosi,
    input  logic                miso,
    output logic [NCS-1:0]      cs_n
);
    import spi_cs_pkg::*;

    localparam int IDXW   = $clog2(NCS);
    localparam int TMRW   = DW + $clog2(DLY_UNIT) + 1;
    localparam int B_HOLD = DW + NCS;
    localparam int B_DEC  = DW + NCS + 1;
    localparam int B_LAST = DW + NCS + 2;

    typedef struct packed {
        seq_state_e                state;
        logic                      hold_full;
        logic [DW-1:0]             hold_data;
        logic [NCS-1:0]            hold_code;
        logic [NCS-1:0]            cur_code;
        logic                      active;
        logic                      cur_last;
        logic                      last_req;
        logic                      decoded;
        logic [DW-1:0]             half;
        logic [TMRW-1:0]           timer;
        logic                      gap_cnt;
        logic [DW-1:0]             rx_data;
        logic                      rx_full;
        logic [NCS-1:0]            cfg_hold;
        logic [NCS-1:0][DW-1:0]    cfg_dly;
    } seq_t;

    seq_t q_d, q_q;

    logic           tick, clk_en, step, sh_done, load;
    logic [DW-1:0]  sh_rx;
    logic [IDXW-1:0] cur_idx;
    logic [NCS-1:0] wcode;

    assign clk_en  = (q_q.state == ST_LEAD) || (q_q.state == ST_SHIFT) ||
                     (q_q.state == ST_GAP);
    assign step    = tick && (q_q.state == ST_SHIFT);
    assign cur_idx = q_q.cur_code[IDXW-1:0];

    spi_cs_clkgen #(.DIVW(DW)) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clk_en),
        .half  (q_q.half),
        .tick  (tick)
    );

    spi_cs_shifter #(.DW(DW)) u_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .ld_data (q_q.hold_data),
        .step    (step),
        .miso    (miso),
        .sck     (sck),
        .mosi    (mosi),
        .done    (sh_done),
        .rx_word (sh_rx)
    );

    spi_cs_selmap #(.NCS(NCS)) u_map (
        .active  (q_q.active),
        .decoded (q_q.decoded),
        .code    (q_q.cur_code),
        .cs_n    (cs_n)
    );

    always_comb begin
        q_d  = q_q;
        load = 1'b0;

        wcode = '0;
        if (q_q.decoded) wcode = wr_data[DW +: NCS];
        else             wcode[IDXW-1:0] = wr_data[DW +: IDXW];

        if (wr_en) begin
            case (wr_addr)
                ADDR_TXD: begin
                    if (!q_q.hold_full && !(q_q.decoded && (wcode == '1))) begin
                        q_d.hold_full = 1'b1;
                        q_d.hold_data = wr_data[DW-1:0];
                        q_d.hold_code = wcode;
                    end
                end
                ADDR_CFG: begin
                    q_d.cfg_hold[wr_data[DW +: IDXW]] = wr_data[B_HOLD];
                    q_d.cfg_dly[wr_data[DW +: IDXW]]  = wr_data[DW-1:0];
                end
                ADDR_MODE: begin
                    q_d.half     = wr_data[DW-1:0];
                    q_d.decoded  = wr_data[B_DEC];
                    q_d.last_req = wr_data[B_LAST];
                end
                default: ;
            endcase
        end

        if (rd_en) q_d.rx_full = 1'b0;

        case (q_q.state)
            ST_IDLE: begin
                if (q_q.hold_full) begin
                    if (q_q.active && (q_q.hold_code != q_q.cur_code)) begin
                        q_d.active  = 1'b0;
                        q_d.gap_cnt = 1'b0;
                        q_d.state   = ST_GAP;
                    end else begin
                        load = 1'b1;
                    end
                end
            end
            ST_LEAD: begin
                if (tick) q_d.state = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (sh_done) begin
                    q_d.rx_data = sh_rx;
                    q_d.rx_full = 1'b1;
                    q_d.timer   = TMRW'(q_q.cfg_dly[cur_idx]) * TMRW'(DLY_UNIT);
                    q_d.state   = ST_DELAY;
                end
            end
            ST_DELAY: begin
                if (q_q.timer != '0) begin
                    q_d.timer = q_q.timer - TMRW'(1);
                end else if (q_q.cur_last) begin
                    q_d.active   = 1'b0;
                    q_d.last_req = 1'b0;
                    q_d.gap_cnt  = 1'b0;
                    q_d.state    = q_q.hold_full ? ST_GAP : ST_IDLE;
                end else if (q_q.hold_full && (q_q.hold_code == q_q.cur_code)) begin
                    load = 1'b1;
                end else if (q_q.hold_full) begin
                    q_d.active  = 1'b0;
                    q_d.gap_cnt = 1'b0;
                    q_d.state   = ST_GAP;
                end else begin
                    q_d.active = q_q.cfg_hold[cur_idx];
                    q_d.state  = ST_IDLE;
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (q_q.gap_cnt) load = 1'b1;
                    else             q_d.gap_cnt = 1'b1;
                end
            end
            default: q_d.state = ST_IDLE;
        endcase

        if (load) begin
            q_d.hold_full = 1'b0;
            q_d.cur_code  = q_q.hold_code;
            q_d.cur_last  = q_q.last_req;
            q_d.active    = 1'b1;
            q_d.state     = ST_LEAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q      <= '0;
            q_q.half <= DW'(2);
        end else begin
            q_q <= q_d;
        end
    end

    assign tx_empty = !q_q.hold_full;
    assign rx_full  = q_q.rx_full;
    assign rx_data  = q_q.rx_data;

    // R2: the serial clock only runs during the shift phase
    a_r2_sck_only_shift: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> (q_q.state == ST_SHIFT));

    // R10: the no-slave code never appears while shifting
    a_r10_no_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.state == ST_SHIFT) |-> (cs_n != '1));

    // R3: a finished word always flags the receive byte
    a_r3_rx_full_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done |=> rx_full);

    // R4: moving the byte into the shifter frees the holding register
    a_r4_empty_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> tx_empty);

    // R7: all lines are released during the switch gap
    a_r7_gap_released: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.state == ST_GAP) |-> (cs_n == '1));

    // R8: a flagged word releases its select at the decision point
    a_r8_last_release: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.state == ST_DELAY && q_q.timer == '0 && q_q.cur_last) |=> (cs_n == '1));

    // R6: hold keeps the select low when nothing is pending
    a_r6_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.state == ST_DELAY && q_q.timer == '0 && !q_q.cur_last &&
         !q_q.hold_full && q_q.cfg_hold[cur_idx]) |=> (cs_n != '1));

endmodule

// File: tb/spi_cs_seq_test.sv
`timescale 1ns/1ps
module spi_cs_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [14:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        tx_empty, rx_full, sck, mosi;
    logic [7:0]  rx_data;
    logic [3:0]  cs_n;
    logic        inv = 1'b0;
    logic        miso;

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;

    int cs_changes = 0, sck_rises = 0, f_run = 0, last_gap = 0, hi_run = 0, last_hi = 0;
    logic [7:0] cap = '0;
    logic [3:0] cs_at_sck = 4'hF, prev_cs = 4'hF;
    logic       prev_sck = 1'b0;

    assign miso = mosi ^ inv;

    always #2.5 clk = ~clk;

    spi_cs_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .tx_empty(tx_empty),
        .rx_full(rx_full), .rx_data(rx_data), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    always @(negedge clk) begin
        if (cs_n != prev_cs) cs_changes++;
        prev_cs = cs_n;
        if (cs_n == 4'hF) f_run++;
        else begin
            if (f_run != 0) last_gap = f_run;
            f_run = 0;
        end
        if (sck && !prev_sck) begin
            sck_rises++;
            cap = {cap[6:0], mosi};
            cs_at_sck = cs_n;
        end
        if (sck) hi_run++;
        else begin
            if (hi_run != 0) last_hi = hi_run;
            hi_run = 0;
        end
        prev_sck = sck;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [14:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clr_mon();
        @(negedge clk);
        #1;
        cs_changes = 0; sck_rises = 0; f_run = 0; last_gap = 0;
        last_hi = 0; cap = '0; cs_at_sck = 4'hF;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rx();
        int k = 0;
        while (!rx_full && k < 1000) begin
            @(negedge clk);
            k++;
        end
    endtask

    // {inv, idx[1:0], byte}
    localparam logic [10:0] VEC [0:5] = '{
        11'h0A5, 11'h13C, 11'h2F0, 11'h30F, 11'h481, 11'h75A
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", cs_n, 4'hF);
        chk("R1 sck", sck, 0);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_full", rx_full, 0);

        // table walk: single words, normal mode, loopback straight/inverted
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b;
            logic [1:0] ix;
            b  = VEC[i][7:0];
            ix = VEC[i][9:8];
            inv = VEC[i][10];
            clr_mon();
            wr(2'd0, {3'b000, 2'b00, ix, b});
            idle(120);
            chk("R2 mosi byte", cap, b);
            chk("R2 sck pulses", sck_rises, 8);
            chk("R3 rx_full set", rx_full, 1);
            chk("R3 rx_data", rx_data, b ^ {8{VEC[i][10]}});
            chk("R11 line low", cs_at_sck, 4'hF ^ (4'b0001 << ix));
            chk("R11 cs edges", cs_changes, 2);
            rd();
            chk("R3 rx_full cleared", rx_full, 0);
        end
        inv = 1'b0;

        // R4 holding register timing
        wr(2'd0, 15'h00C3);
        chk("R4 empty falls", tx_empty, 0);
        @(negedge clk);
        chk("R4 empty rises on load", tx_empty, 1);
        chk("R4 select low", cs_n, 4'hE);
        idle(120);
        rd();

        // R5 fast reload keeps select low
        clr_mon();
        wr(2'd0, 15'h0111);
        while (!tx_empty) @(negedge clk);
        wr(2'd0, 15'h0122);
        idle(200);
        chk("R5 fast reload cs edges", cs_changes, 2);
        chk("R5 fast reload pulses", sck_rises, 16);
        chk("R5 second byte", rx_data, 8'h22);
        rd();

        // R5 slow reload with zero delay releases
        clr_mon();
        wr(2'd0, 15'h0133);
        wait_rx();
        wr(2'd0, 15'h0144);
        idle(200);
        chk("R5 slow reload cs edges", cs_changes, 4);
        rd();

        // R5 delay window catches the late reload
        wr(2'd1, {3'b000, 4'b0001, 8'd2});
        clr_mon();
        wr(2'd0, 15'h0155);
        wait_rx();
        idle(20);
        wr(2'd0, 15'h0166);
        idle(300);
        chk("R5 delay window cs edges", cs_changes, 2);
        wr(2'd1, {3'b000, 4'b0001, 8'd0});
        rd();

        // R6 hold keeps select, R7 switch gap
        wr(2'd1, {3'b001, 4'b0010, 8'd0});
        clr_mon();
        wr(2'd0, 15'h0277);
        idle(300);
        chk("R6 held low", cs_n, 4'hB);
        chk("R6 one edge", cs_changes, 1);
        wr(2'd0, 15'h0088);
        idle(300);
        chk("R7 switch edges", cs_changes, 4);
        chk("R7 gap clocks", last_gap, 4);
        chk("R7 new select used", cs_at_sck, 4'hE);
        rd();

        // R8 last-transfer flag
        clr_mon();
        wr(2'd0, 15'h0299);
        idle(200);
        chk("R8 held before flag", cs_n, 4'hB);
        wr(2'd2, {3'b100, 4'b0000, 8'd2});
        wr(2'd0, 15'h02AA);
        idle(200);
        chk("R8 released by flag", cs_n, 4'hF);
        wr(2'd0, 15'h02BB);
        idle(200);
        chk("R8 flag cleared", cs_n, 4'hB);
        wr(2'd1, {3'b000, 4'b0010, 8'd0});
        wr(2'd0, 15'h00CC);
        idle(300);
        chk("R8 cleanup release", cs_n, 4'hF);
        rd();

        // R9 divider and clamp
        wr(2'd2, {3'b000, 4'b0000, 8'd5});
        clr_mon();
        wr(2'd0, 15'h0055);
        idle(400);
        chk("R9 half 5", last_hi, 5);
        wr(2'd2, {3'b000, 4'b0000, 8'd1});
        clr_mon();
        wr(2'd0, 15'h0055);
        idle(200);
        chk("R9 clamp to 2", last_hi, 2);
        rd();

        // R10 decoded mode
        wr(2'd2, {3'b010, 4'b0000, 8'd2});
        clr_mon();
        wr(2'd0, {3'b000, 4'h9, 8'h3C});
        idle(200);
        chk("R10 code on lines", cs_at_sck, 4'h9);
        chk("R10 decoded edges", cs_changes, 2);
        chk("R10 decoded byte", cap, 8'h3C);
        clr_mon();
        wr(2'd0, {3'b000, 4'hF, 8'h12});
        chk("R10 code F ignored", tx_empty, 1);
        idle(100);
        chk("R10 no select change", cs_changes, 0);
        chk("R10 no clock", sck_rises, 0);
        wr(2'd2, {3'b000, 4'b0000, 8'd2});

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule